// File: doc/BRIEF.md
# Receive Frame Queue with DMA Request

This block queues received bus frames that an upstream acceptance filter has already passed. Each entry holds a 128-bit message structure, read as four 32-bit words, and the index of the filter element that matched it. The oldest frame is shown in a fixed read window of four words. A read-only hit register gives the filter index of that same frame.

A frames-available flag is high whenever the queue holds a frame. There are two service modes. In CPU mode, writing 1 to the flag-clear input releases the head frame. In DMA mode the flag also drives a DMA request, and a DMA read of the last window word releases the head frame. Queue operation needs the enable input. DMA mode needs both the enable input and the DMA-mode input. The DMA-mode input is expected to be low out of reset. A clear command empties the queue and must be issued before DMA mode is turned off.

Top module: `rx_frame_fifo`

## Requirements
- R1: After reset the queue is empty, `frames_avail`, `dma_req` and `overflow` are low, and every read returns zero.
- R2: While `fifo_en` is low, incoming frames are discarded and `frames_avail` and `dma_req` stay low. A frame offered in that state is not present after `fifo_en` rises.
- R3: While `fifo_en` is high, `frames_avail` is high exactly when at least one frame is held. It rises in the cycle after a frame is written into an empty queue.
- R4: A read at `rd_addr` 0x80, 0x84, 0x88 or 0x8C returns bits [31:0], [63:32], [95:64] or [127:96] of the head frame. Frames leave the queue in the order they were written.
- R5: A read at `rd_addr` 0x18 returns the head frame's hit index, zero-extended, while `frames_avail` is high. It returns zero while the queue is empty.
- R6: In CPU mode (`dma_en` low), a `flag_clr` pulse with a frame present releases the head frame. If frames remain, `frames_avail` stays high and the next frame appears in the window.
- R7: In DMA mode, `dma_req` is high whenever `frames_avail` is high, except in the cycle described by R8. A read of 0x8C with `rd_is_dma` high releases the head frame.
- R8: In the cycle after each release in DMA mode, `dma_req` is low. It returns high in the following cycle if frames remain.
- R9: Window reads from the port that does not own the mode return zero and release nothing. In DMA mode these are reads with `rd_is_dma` low. In CPU mode these are reads with `rd_is_dma` high. In DMA mode, `flag_clr` has no effect.
- R10: The queue holds 6 frames. A frame written while it is full is discarded, and `overflow` is set and stays set.
- R11: A `fifo_clr` pulse empties the queue and clears `overflow`. It takes priority over a write in the same cycle.
- R12: Reads of any address other than the window and the hit register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Queue enable |
| dma_en | input | 1 | DMA service mode select (effective only with fifo_en) |
| wr_valid | input | 1 | Accepted frame strobe from the filter |
| wr_frame | input | 128 | Message structure of the accepted frame |
| wr_hit | input | 9 | Index of the matching filter element |
| rd_en | input | 1 | Read strobe |
| rd_is_dma | input | 1 | Read comes from the DMA engine |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, combinational |
| flag_clr | input | 1 | Write-1 to the frames-available flag |
| fifo_clr | input | 1 | Clear-queue command |
| frames_avail | output | 1 | At least one frame held |
| dma_req | output | 1 | DMA service request |
| overflow | output | 1 | Sticky frame-lost indication |

## Verification
The hardest state to reach from the ports is the one-cycle gap in `dma_req` that follows a DMA release while frames still remain. Seeing it needs two queued frames in DMA mode and a DMA-port read of the last word. The bench then samples the request in the cycle right after that read and again in the next cycle. A second difficult state is a clear that arrives together with a write. The stimulus drives both strobes in the same cycle and then checks that the queue is empty and `overflow` is low.

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo #(
  parameter int DEPTH    = 6,
  parameter int IDX_W    = 9,
  parameter int AW       = 8,
  parameter logic [7:0] WIN_BASE = 8'h80,
  parameter logic [7:0] HIT_ADDR = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              dma_en,
  input  logic              wr_valid,
  input  logic [127:0]      wr_frame,
  input  logic [IDX_W-1:0]  wr_hit,
  input  logic              rd_en,
  input  logic              rd_is_dma,
  input  logic [AW-1:0]     rd_addr,
  output logic [31:0]       rd_data,
  input  logic              flag_clr,
  input  logic              fifo_clr,
  output logic              frames_avail,
  output logic              dma_req,
  output logic              overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [127:0]     frames [DEPTH];
  logic [IDX_W-1:0] hits   [DEPTH];
  logic [PW-1:0]    head, tail;
  logic [CW-1:0]    count;
  logic             gap;

  wire dma_mode = fifo_en & dma_en;
  wire full     = (count == FULL);
  wire held     = (count != '0);
  wire in_win   = (rd_addr[AW-1:4] == WIN_BASE[AW-1:4]) && (rd_addr[1:0] == 2'b00);
  wire last_wd  = (rd_addr == AW'(WIN_BASE + 8'hC));
  wire owner    = dma_mode ? rd_is_dma : ~rd_is_dma;

  wire pop_cpu  = ~dma_mode & flag_clr;
  wire pop_dma  = dma_mode & rd_en & rd_is_dma & last_wd;
  wire pop      = fifo_en & held & ~fifo_clr & (pop_cpu | pop_dma);
  wire push     = fifo_en & wr_valid & ~full & ~fifo_clr;
  wire lost     = fifo_en & wr_valid & full & ~fifo_clr;

  assign frames_avail = fifo_en & held;
  assign dma_req      = dma_mode & held & ~gap;

  always_comb begin
    rd_data = '0;
    if (rd_en && frames_avail) begin
      if (in_win && owner) begin
        case (rd_addr[3:2])
          2'd0: rd_data = frames[head][31:0];
          2'd1: rd_data = frames[head][63:32];
          2'd2: rd_data = frames[head][95:64];
          default: rd_data = frames[head][127:96];
        endcase
      end else if (rd_addr == AW'(HIT_ADDR)) begin
        rd_data = 32'(hits[head]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      frames[tail] <= wr_frame;
      hits[tail]   <= wr_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      count    <= '0;
      gap      <= 1'b0;
      overflow <= 1'b0;
    end else if (fifo_clr) begin
      head     <= '0;
      tail     <= '0;
      count    <= '0;
      gap      <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (push) tail <= (tail == LAST) ? '0 : tail + 1'b1;
      if (pop)  head <= (head == LAST) ? '0 : head + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      gap   <= pop & dma_mode;
      if (lost) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_frame_fifo_chk.sv
module rx_frame_fifo_chk #(
  parameter int AW = 8,
  parameter logic [7:0] WIN_BASE = 8'h80
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          dma_en,
  input logic          rd_en,
  input logic          rd_is_dma,
  input logic [AW-1:0] rd_addr,
  input logic [31:0]   rd_data,
  input logic          fifo_clr,
  input logic          frames_avail,
  input logic          dma_req,
  input logic          overflow
);
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (!frames_avail && !dma_req));

  a_r7_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (frames_avail && dma_en && fifo_en));

  a_r8_req_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && dma_en && rd_en && rd_is_dma && frames_avail && !fifo_clr &&
     rd_addr == AW'(WIN_BASE + 8'hC)) |=> !dma_req);

  a_r9_cpu_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && dma_en && rd_en && !rd_is_dma &&
     rd_addr[AW-1:4] == WIN_BASE[AW-1:4]) |-> (rd_data == 32'd0));

  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !fifo_clr) |=> overflow);

  a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (!frames_avail && !overflow));
endmodule

bind rx_frame_fifo rx_frame_fifo_chk #(.AW(AW), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_en(dma_en),
  .rd_en(rd_en), .rd_is_dma(rd_is_dma), .rd_addr(rd_addr), .rd_data(rd_data),
  .fifo_clr(fifo_clr), .frames_avail(frames_avail), .dma_req(dma_req),
  .overflow(overflow)
);

// File: tb/rx_frame_fifo_test.sv
module rx_frame_fifo_test;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, dma_en = 0, wr_valid = 0, rd_en = 0, rd_is_dma = 0;
  logic flag_clr = 0, fifo_clr = 0;
  logic [127:0] wr_frame = '0;
  logic [8:0]   wr_hit = '0;
  logic [7:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic frames_avail, dma_req, overflow;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_frame_fifo uut (.*);

  function automatic logic [31:0] wd(int f, int k);
    return 32'hC000_0000 | (32'(f) << 8) | 32'(k);
  endfunction

  function automatic logic [127:0] frm(int f);
    return {wd(f, 3), wd(f, 2), wd(f, 1), wd(f, 0)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(int f, int h);
    @(negedge clk);
    wr_valid = 1; wr_frame = frm(f); wr_hit = 9'(h);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd(logic [7:0] a, logic dma, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1; rd_addr = a; rd_is_dma = dma;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic pulse_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); fifo_clr = 1;
    @(negedge clk); fifo_clr = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 flag", 32'(frames_avail), 0);
    chk("R1 req", 32'(dma_req), 0);
    chk("R1 overflow", 32'(overflow), 0);
    rd(8'h80, 0, v); chk("R1 window", v, 0);
    rd(8'h18, 0, v); chk("R1 hit", v, 0);
  endtask

  task automatic t_disabled();
    push(90, 3);
    chk("R2 flag off", 32'(frames_avail), 0);
    fifo_en = 1;
    @(negedge clk);
    chk("R2 nothing kept", 32'(frames_avail), 0);
  endtask

  task automatic t_cpu();
    logic [31:0] v;
    push(1, 5);
    chk("R3 flag after write", 32'(frames_avail), 1);
    push(2, 6); push(3, 7);
    for (int k = 0; k < 4; k++) begin
      rd(8'(8'h80 + 4 * k), 0, v); chk("R4 word", v, wd(1, k));
    end
    chk("R4 no pop on read", 32'(frames_avail), 1);
    rd(8'h18, 0, v); chk("R5 hit", v, 5);
    rd(8'h40, 0, v); chk("R12 other addr", v, 0);
    rd(8'h8C, 1, v); chk("R9 dma port in cpu mode", v, 0);
    chk("R6 req low in cpu mode", 32'(dma_req), 0);
    pulse_flag();
    chk("R6 flag stays", 32'(frames_avail), 1);
    rd(8'h80, 0, v); chk("R6 next frame", v, wd(2, 0));
    rd(8'h18, 0, v); chk("R5 next hit", v, 6);
    pulse_flag(); pulse_flag();
    chk("R3 empty flag", 32'(frames_avail), 0);
    rd(8'h18, 0, v); chk("R5 hit when empty", v, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    for (int f = 10; f < 17; f++) push(f, f);
    chk("R10 overflow set", 32'(overflow), 1);
    for (int f = 10; f < 16; f++) begin
      rd(8'h8C, 0, v); chk("R10 order", v, wd(f, 3));
      pulse_flag();
    end
    chk("R10 seventh dropped", 32'(frames_avail), 0);
    chk("R10 overflow sticky", 32'(overflow), 1);
    pulse_clr();
    chk("R11 overflow cleared", 32'(overflow), 0);
  endtask

  task automatic t_clear();
    push(20, 1); push(21, 2);
    @(negedge clk);
    fifo_clr = 1; wr_valid = 1; wr_frame = frm(22);
    @(negedge clk);
    fifo_clr = 0; wr_valid = 0;
    chk("R11 clear wins", 32'(frames_avail), 0);
  endtask

  task automatic t_dma();
    logic [31:0] v;
    dma_en = 1;
    push(30, 11); push(31, 12);
    chk("R7 req with flag", 32'(dma_req), 1);
    rd(8'h80, 0, v); chk("R9 cpu read zero", v, 0);
    pulse_flag();
    rd(8'h18, 0, v); chk("R9 flag_clr ignored", v, 11);
    chk("R9 req kept", 32'(dma_req), 1);
    for (int k = 0; k < 3; k++) begin
      rd(8'(8'h80 + 4 * k), 1, v); chk("R7 dma word", v, wd(30, k));
    end
    rd(8'h8C, 1, v); chk("R7 dma last word", v, wd(30, 3));
    chk("R8 req gap", 32'(dma_req), 0);
    chk("R8 flag kept", 32'(frames_avail), 1);
    @(negedge clk);
    chk("R8 req back", 32'(dma_req), 1);
    rd(8'h18, 0, v); chk("R7 next hit", v, 12);
    rd(8'h8C, 1, v); chk("R7 second frame", v, wd(31, 3));
    chk("R7 empty", 32'(frames_avail), 0);
    @(negedge clk);
    chk("R7 no req when empty", 32'(dma_req), 0);
    pulse_clr();
    dma_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_cpu();
    t_overflow();
    t_clear();
    t_dma();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule